// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the device-side command front end of a small serial NOR flash. It watches the serial clock, chip select and data-in pins, builds opcodes, 24-bit addresses and dummy bytes, and drives status, identification and array read data back on the serial output. It owns the write-enable latch, the busy (write-in-progress) flag, the writable upper status bits and the deep power-down state. Program, erase and status-write cycles are handed to an external array controller. The engine raises a job request and holds it until the controller pulses a done signal.

The serial pins are oversampled by the system clock. Each high phase and each low phase of the serial clock must last at least three system clock cycles. The array controller answers `rd_addr` with `rd_data` combinationally, or within one system clock. Page data leaves on a valid/ready stream (`wr_*`). A beat stays presented, with address and data held stable, until `wr_ready` is seen high. The serial link cannot stall, so the sink must take each beat within eight serial clock periods, before the next byte completes. A program job is committed by the job request. `wr_first` marks the first beat of each program instruction so that the controller can drop anything staged by an aborted one.

Top module: `flash_cmd_engine`

## Requirements
- R1: Input bits are taken on rising serial clock edges and output bits change on falling edges, MSB first. The block works with the clock idling low (mode 0) and with the clock idling high (mode 3).
- R2: Opcode 05h returns the status byte {upper bits[7:2], write-enable bit1, busy bit0}. The byte repeats for as long as chip select stays low. `so_en` is high only while output data is being driven.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it. Each takes effect only when chip select rises after exactly one byte.
- R4: Opcode 03h takes a 24-bit address, ignores bits 23..19, and returns array bytes from consecutive addresses with no dummy byte. After 7FFFFh the next address is 00000h.
- R5: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address before data starts.
- R6: Opcode 9Fh returns 37h, 30h, 13h. Opcode ABh returns 12h, repeated, after three dummy bytes, and it leaves deep power-down when chip select rises after whole bytes.
- R7: With write enable set, opcode 02h sends each data byte after the address as one `wr` beat. Beat addresses advance in the low 8 bits only, wrapping within the 256-byte page. `wr_first` marks the first beat. When chip select rises after whole bytes (at least one data byte), a job of kind 0 is requested.
- R8: Opcode 20h (kind 1) and opcode D8h (kind 2) each need exactly four bytes. Opcode 01h with exactly two bytes loads status bits [7:2] from the data byte and requests kind 3. Without write enable, none of these, nor 02h, requests a job or emits a beat.
- R9: From job start until `op_done`, `op_req` and the busy bit stay high and `op_kind`/`op_addr` hold the job (address bits 18..0). `op_done` clears busy, write enable and `op_req`.
- R10: While busy, only 05h and ABh are decoded. Any other opcode produces no output and no state change.
- R11: Opcode B9h with exactly one byte enters deep power-down, but only when not busy. In deep power-down only ABh is decoded.
- R12: When chip select rises mid-byte, including mid-opcode, the instruction is discarded and the next one decodes normally.
- R13: After reset the status byte reads 00h and `op_req`, `wr_valid` and `so_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data into the device |
| so | output | 1 | Serial data out of the device |
| so_en | output | 1 | Output data valid / drive enable |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_valid | output | 1 | Page data beat valid |
| wr_ready | input | 1 | Sink accepts the beat |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | 8 | Beat data |
| wr_first | output | 1 | First beat of a program instruction |
| op_req | output | 1 | Job request, held until done |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 status write |
| op_addr | output | ADDR_W | Job address |
| op_done | input | 1 | Job completion pulse |

## Verification
A wrong write-enable or busy value shows up in the next status read. It shows up sooner as a missing or extra `op_req` in the system clock cycle after chip select rises. A slip in the bit or byte counters shifts every returned byte by a bit position, or moves where data starts after the address. This is visible in the first output byte of a read, fast read or identification. A bad acceptance rule appears as output driven, or state changed, by an opcode that should have been inert while busy or asleep. An address counter fault appears only at the wrap points: the 7FFFFh-to-0 read wrap and the 256-byte page wrap on `wr_addr`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam logic [7:0] OP_BERASE = 8'hD8;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  localparam logic [7:0] ID_MAKER  = 8'h37;
  localparam logic [7:0] ID_FAMILY = 8'h30;
  localparam logic [7:0] ID_SIZE   = 8'h13;
  localparam logic [7:0] SIG_BYTE  = 8'h12;

  typedef enum logic [1:0] {
    JOB_PROG = 2'd0,
    JOB_SECT = 2'd1,
    JOB_BLK  = 2'd2,
    JOB_SREG = 2'd3
  } job_e;
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             tx_load,
  input  logic [7:0]       tx_byte,
  output logic [7:0]       rx_byte,
  output logic             byte_done,
  output logic [CNT_W-1:0] byte_idx,
  output logic [2:0]       bit_idx,
  output logic             cs_rise,
  output logic             so
);
  logic       sck_q, cs_q, rise, fall;
  logic [6:0] sh;
  logic [7:0] tx_sh;

  assign rise      = ~cs_n & sck & ~sck_q;
  assign fall      = ~cs_n & ~sck & sck_q;
  assign byte_done = rise & (bit_idx == 3'd7);
  assign rx_byte   = {sh, mosi};
  assign cs_rise   = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      sh       <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      tx_sh    <= '0;
      so       <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bit_idx  <= '0;
        byte_idx <= '0;
        so       <= 1'b0;
      end else if (rise) begin
        sh      <= {sh[5:0], mosi};
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7 && byte_idx != '1) byte_idx <= byte_idx + 1'b1;
      end
      if (tx_load) begin
        tx_sh <= tx_byte;
      end else if (fall) begin
        so    <= tx_sh[7];
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  // R1
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bit_idx == 3'd7) |=> (bit_idx == 3'd0 || cs_n));
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [7:0]        op,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [5:0]        sr_in,
  input  logic              op_done,
  output logic              wel,
  output logic              wip,
  output logic              dpd,
  output logic [5:0]        sr_keep,
  output logic              op_req,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr
);
  localparam logic [CNT_W-1:0] N1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] N2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] N4 = CNT_W'(4);
  localparam logic [CNT_W-1:0] N5 = CNT_W'(5);

  logic       start;
  logic [1:0] kind;

  always_comb begin
    start = 1'b0;
    kind  = JOB_PROG;
    if (fire && wel) begin
      case (op)
        OP_PROG:   begin start = (nbytes >= N5); kind = JOB_PROG; end
        OP_SERASE: begin start = (nbytes == N4); kind = JOB_SECT; end
        OP_BERASE: begin start = (nbytes == N4); kind = JOB_BLK;  end
        OP_WRSR:   begin start = (nbytes == N2); kind = JOB_SREG; end
        default:   start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; wip <= 1'b0; dpd <= 1'b0; sr_keep <= '0;
      op_req <= 1'b0; op_kind <= '0; op_addr <= '0;
    end else if (op_done && wip) begin
      wip <= 1'b0; wel <= 1'b0; op_req <= 1'b0;
    end else if (start) begin
      wip <= 1'b0 | 1'b1; op_req <= 1'b1; op_kind <= kind; op_addr <= addr;
      if (kind == JOB_SREG) sr_keep <= sr_in;
    end else if (fire) begin
      case (op)
        OP_WREN:  if (nbytes == N1) wel <= 1'b1;
        OP_WRDI:  if (nbytes == N1) wel <= 1'b0;
        OP_SLEEP: if (nbytes == N1 && !wip) dpd <= 1'b1;
        OP_WAKE:  dpd <= 1'b0;
        default:  ;
      endcase
    end
  end

  // R9
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && wip) |=> (!wip && !wel && !op_req));
  // R8
  start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_req) |-> $past(wel));
  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpd) |-> !$past(wip));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              so,
  output logic              so_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_first,
  output logic              op_req,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  input  logic              op_done
);
  localparam logic [CNT_W-1:0] IX_OP   = CNT_W'(0);
  localparam logic [CNT_W-1:0] IX_ID1  = CNT_W'(1);
  localparam logic [CNT_W-1:0] IX_ID2  = CNT_W'(2);
  localparam logic [CNT_W-1:0] IX_ID3  = CNT_W'(3);
  localparam logic [CNT_W-1:0] IX_DATA = CNT_W'(4);
  localparam logic [CNT_W-1:0] IX_FAST = CNT_W'(5);

  logic [7:0]        rx, tx_next, opc, sr_data;
  logic              byte_done, cs_rise, ld_p, op_ok, out_next, rd_take, fire;
  logic [CNT_W-1:0]  byte_idx;
  logic [2:0]        bit_idx;
  logic [ADDR_W-1:0] addr;
  logic              wel, wip, dpd;
  logic [5:0]        sr_keep;

  spi_bit_engine #(.CNT_W(CNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_load(ld_p), .tx_byte(tx_next), .rx_byte(rx), .byte_done(byte_done),
    .byte_idx(byte_idx), .bit_idx(bit_idx), .cs_rise(cs_rise), .so(so)
  );

  assign fire = cs_rise & op_ok & (bit_idx == 3'd0) & (byte_idx != IX_OP);

  flash_status_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(opc), .nbytes(byte_idx),
    .addr(addr), .sr_in(sr_data[7:2]), .op_done(op_done), .wel(wel),
    .wip(wip), .dpd(dpd), .sr_keep(sr_keep), .op_req(op_req),
    .op_kind(op_kind), .op_addr(op_addr)
  );

  function automatic logic accept(input logic [7:0] b, input logic sleep, input logic busy);
    if (sleep)     return b == OP_WAKE;
    else if (busy) return (b == OP_RDSR) || (b == OP_WAKE);
    else           return 1'b1;
  endfunction

  always_comb begin
    tx_next  = 8'h00;
    out_next = 1'b0;
    rd_take  = 1'b0;
    if (op_ok) begin
      case (opc)
        OP_RDSR: begin out_next = 1'b1; tx_next = {sr_keep, wel, wip}; end
        OP_RDID: begin
          out_next = 1'b1;
          if (byte_idx == IX_ID1)      tx_next = ID_MAKER;
          else if (byte_idx == IX_ID2) tx_next = ID_FAMILY;
          else if (byte_idx == IX_ID3) tx_next = ID_SIZE;
        end
        OP_READ: if (byte_idx >= IX_DATA) begin out_next = 1'b1; rd_take = 1'b1; tx_next = rd_data; end
        OP_FAST: if (byte_idx >= IX_FAST) begin out_next = 1'b1; rd_take = 1'b1; tx_next = rd_data; end
        OP_WAKE: if (byte_idx >= IX_DATA) begin out_next = 1'b1; tx_next = SIG_BYTE; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_p <= 1'b0; op_ok <= 1'b0; opc <= '0; sr_data <= '0; addr <= '0;
      so_en <= 1'b0; wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_first <= 1'b0;
    end else begin
      ld_p <= byte_done;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (byte_done) begin
        if (byte_idx == IX_OP) begin
          opc   <= rx;
          op_ok <= accept(rx, dpd, wip);
        end else if (byte_idx <= IX_ID3) begin
          addr <= {addr[ADDR_W-9:0], rx};
          if (byte_idx == IX_ID1) sr_data <= rx;
        end else if (op_ok && wel && opc == OP_PROG) begin
          wr_valid <= 1'b1;
          wr_addr  <= addr;
          wr_data  <= rx;
          wr_first <= (byte_idx == IX_DATA);
          addr     <= {addr[ADDR_W-1:8], addr[7:0] + 8'd1};
        end
      end
      if (ld_p) begin
        so_en <= out_next;
        if (rd_take) addr <= addr + 1'b1;
      end
      if (cs_n) begin
        op_ok <= 1'b0;
        so_en <= 1'b0;
      end
    end
  end

  assign rd_addr = addr;

  // R7
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  // R2
  quiet_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_en);
  // R10
  busy_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && byte_done && byte_idx == IX_OP && rx != OP_RDSR && rx != OP_WAKE) |=> !op_ok);
endmodule

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;
  localparam int AW = 19;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, op_done = 1'b0;
  logic wr_ready = 1'b0;
  logic so, so_en, wr_valid, wr_first, op_req;
  logic [AW-1:0] rd_addr, wr_addr, op_addr;
  logic [7:0] rd_data, wr_data;
  logic [1:0] op_kind;

  int checks = 0, failures = 0, nb = 0;
  bit m3 = 1'b0, en_seen = 1'b0;
  logic [AW-1:0] cap_a [8];
  logic [7:0]    cap_d [8];
  logic          cap_f [8];

  always #2 clk = ~clk;

  function automatic logic [7:0] arr(input logic [AW-1:0] a);
    return a[7:0] ^ {a[18:16], a[12:8]};
  endfunction
  assign rd_data = arr(rd_addr);

  flash_cmd_engine i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .so(so),
    .so_en(so_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_first(wr_first),
    .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr), .op_done(op_done)
  );

  always @(posedge clk) begin
    wr_ready <= ~wr_ready;
    if (rst_n && wr_valid && wr_ready && nb < 8) begin
      cap_a[nb] = wr_addr; cap_d[nb] = wr_data; cap_f[nb] = wr_first; nb = nb + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    sck = m3; tick(2); cs_n = 1'b0; en_seen = 1'b0; tick(4);
  endtask

  task automatic cs_high();
    sck = m3; tick(4); cs_n = 1'b1; tick(4);
  endtask

  task automatic xfer(input logic [7:0] d, input int n, output logic [7:0] r);
    r = 8'h00;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; mosi = d[7-i]; tick(4);
      r = {r[6:0], so}; en_seen = en_seen | so_en;
      sck = 1'b1; tick(4);
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_low(); xfer(op, 8, r); cs_high();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    xfer(op, 8, r); xfer(a[23:16], 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_low(); xfer(8'h05, 8, r); xfer(8'h00, 8, s); cs_high();
  endtask

  task automatic finish_job();
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
    tick(2);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R13 so_en", so_en, 0); chk("R13 op_req", op_req, 0); chk("R13 wr_valid", wr_valid, 0);
    rdsr(s); chk("R13 status", s, 8'h00);
  endtask

  task automatic t_wel();
    logic [7:0] s, r;
    cmd1(8'h06);
    cs_low(); xfer(8'h05, 8, r); xfer(0, 8, s); chk("R2 status wel", s, 8'h02);
    xfer(0, 8, s); chk("R2 status repeat", s, 8'h02); cs_high();
    cmd1(8'h04); rdsr(s); chk("R3 wrdi clears", s, 8'h00);
    cs_low(); xfer(8'h06, 8, r); xfer(8'h00, 8, r); cs_high();
    rdsr(s); chk("R3 two-byte wren ignored", s, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] r;
    cs_low(); cmd_addr(8'h03, 24'hF7FFFE);
    xfer(0, 8, r); chk("R4 read first", r, arr(19'h7FFFE));
    xfer(0, 8, r); chk("R4 read top", r, arr(19'h7FFFF));
    xfer(0, 8, r); chk("R4 read wrap", r, arr(19'h00000));
    cs_high();
  endtask

  task automatic t_fast_mode3();
    logic [7:0] r, s;
    m3 = 1'b1;
    cs_low(); cmd_addr(8'h0B, 24'h012345); xfer(0, 8, r);
    xfer(0, 8, r); chk("R5 R1 fast mode3 byte0", r, arr(19'h12345));
    xfer(0, 8, r); chk("R5 R1 fast mode3 byte1", r, arr(19'h12346));
    cs_high();
    cmd1(8'h06); rdsr(s); chk("R1 mode3 wren", s, 8'h02);
    cmd1(8'h04);
    m3 = 1'b0;
  endtask

  task automatic t_ids();
    logic [7:0] r;
    cs_low(); xfer(8'h9F, 8, r);
    xfer(0, 8, r); chk("R6 id maker", r, 8'h37);
    xfer(0, 8, r); chk("R6 id family", r, 8'h30);
    xfer(0, 8, r); chk("R6 id size", r, 8'h13);
    cs_high();
    cs_low(); cmd_addr(8'hAB, 24'h0);
    xfer(0, 8, r); chk("R6 signature", r, 8'h12);
    xfer(0, 8, r); chk("R6 signature repeat", r, 8'h12);
    cs_high();
  endtask

  task automatic t_program();
    logic [7:0] r, s;
    int base;
    base = nb;
    cs_low(); cmd_addr(8'h02, 24'h0012FE); xfer(8'h11, 8, r); cs_high();
    chk("R8 no wel no beat", nb, base); chk("R8 no wel no job", op_req, 0);
    cmd1(8'h06);
    base = nb;
    cs_low(); cmd_addr(8'h02, 24'h0012FE);
    xfer(8'h11, 8, r); xfer(8'h22, 8, r); xfer(8'h33, 8, r); cs_high();
    chk("R7 beat count", nb - base, 3);
    chk("R7 beat0 addr", cap_a[base], 19'h012FE); chk("R7 beat0 data", cap_d[base], 8'h11);
    chk("R7 beat0 first", cap_f[base], 1);
    chk("R7 beat1 addr", cap_a[base+1], 19'h012FF); chk("R7 beat1 first", cap_f[base+1], 0);
    chk("R7 page wrap addr", cap_a[base+2], 19'h01200); chk("R7 beat2 data", cap_d[base+2], 8'h33);
    chk("R7 job req", op_req, 1); chk("R7 job kind", op_kind, 0);
    rdsr(s); chk("R9 busy status", s, 8'h03);
    chk("R9 req held", op_req, 1);
    finish_job();
    chk("R9 req dropped", op_req, 0);
    rdsr(s); chk("R9 done status", s, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] r, s;
    cmd1(8'h06);
    cs_low(); cmd_addr(8'h20, 24'h0A5123); cs_high();
    chk("R8 sector req", op_req, 1); chk("R8 sector kind", op_kind, 1);
    chk("R9 sector addr", op_addr, 19'h25123);
    cs_low(); xfer(8'h9F, 8, r); xfer(0, 8, r); cs_high();
    chk("R10 rdid silent while busy", en_seen, 0);
    cmd1(8'h04); rdsr(s); chk("R10 wrdi ignored while busy", s, 8'h03);
    cmd1(8'hB9); rdsr(s); chk("R11 sleep rejected while busy", en_seen, 1);
    finish_job();
    rdsr(s); chk("R9 erase done", s, 8'h00);
  endtask

  task automatic t_sleep();
    logic [7:0] r, s;
    cmd1(8'hB9);
    rdsr(s); chk("R11 status silent asleep", en_seen, 0);
    cs_low(); cmd_addr(8'h03, 24'h0); xfer(0, 8, r); cs_high();
    chk("R11 read silent asleep", en_seen, 0);
    cs_low(); cmd_addr(8'hAB, 24'h0); xfer(0, 8, r); cs_high();
    chk("R6 wake signature", r, 8'h12);
    rdsr(s); chk("R11 awake status drives", en_seen, 1);
  endtask

  task automatic t_partial();
    logic [7:0] r, s;
    cs_low(); xfer(8'h06, 8, r); xfer(8'h00, 2, r); cs_high();
    rdsr(s); chk("R12 ragged wren discarded", s, 8'h00);
    cmd1(8'h06);
    cs_low(); xfer(8'h04, 4, r); cs_high();
    rdsr(s); chk("R12 partial opcode discarded", s, 8'h02);
    chk("R12 decoder recovers", en_seen, 1);
    cmd1(8'h04);
  endtask

  task automatic t_erase_wrsr();
    logic [7:0] r, s;
    cs_low(); cmd_addr(8'hD8, 24'h030000); cs_high();
    chk("R8 block no wel", op_req, 0);
    cmd1(8'h06);
    cs_low(); cmd_addr(8'hD8, 24'h030000); cs_high();
    chk("R8 block kind", op_kind, 2); chk("R8 block req", op_req, 1);
    finish_job();
    cmd1(8'h06);
    cs_low(); xfer(8'h01, 8, r); xfer(8'hA8, 8, r); cs_high();
    chk("R8 wrsr kind", op_kind, 3);
    rdsr(s); chk("R8 wrsr busy status", s, 8'hAB);
    finish_job();
    rdsr(s); chk("R8 wrsr stored", s, 8'hA8);
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(3);
    t_reset();
    t_wel();
    t_read();
    t_fast_mode3();
    t_ids();
    t_program();
    t_busy();
    t_sleep();
    t_partial();
    t_erase_wrsr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule